// File: doc/BRIEF.md
# Supervisor Watchdog and Reset Generator

This core watches over a processor from inside a synchronous clock domain. It has two duties. The first is to hold the system in reset while supply is low. It also holds reset for a fixed settling delay after power-up and after supply recovery. The second is to raise a reset pulse and a fault flag when software stops toggling its watchdog strobe. All analog sensing happens outside the core. The low-line indication, the watchdog disable qualifier and the timing select arrive as clean synchronous levels. Only the strobe is treated as asynchronous.

Software services the watchdog by toggling `wd_strobe`. A rising edge and a falling edge count the same. A strobe left floating or parked at mid-level is modelled by the `wd_off` qualifier, which switches the watchdog off. The reset delay and both timeout lengths are parameters given in clock cycles. `tsel` picks the short or the long timeout. All pins are plain levels with no handshake. The core never stalls and never applies back-pressure.

Top module: `sup_guard`

## Requirements
- R1: While `rst_n` is low, `rst_out_n` is 0, `wd_fault_n` is 1 and `lowline_n` is 1. After `rst_n` rises, `rst_out_n` stays 0 for exactly RST_DLY rising clock edges and goes to 1 after the RST_DLY-th edge.
- R2: `rst_out` is always the exact inverse of `rst_out_n`.
- R3: Every change of `wd_strobe`, rising or falling, is registered on the third rising edge after it, through a two-flop synchronizer and an edge detector. A registered change restarts the timeout count.
- R4: With `tsel`=0 the timeout is TO_FAST cycles. The timeout is counted from the last clearing edge. A clearing edge is a registered strobe change, the release of reset, or an edge at which `wd_off` was 1. If no strobe change is registered for the timeout, `rst_out_n` and `wd_fault_n` both fall on the TO_FAST-th edge after the last clearing edge.
- R5: A watchdog reset pulse keeps `rst_out_n` at 0 for exactly RST_DLY edges.
- R6: After a timeout, `wd_fault_n` stays 0 until the next registered strobe change. It returns to 1 on that edge, even while the reset pulse is still running.
- R7: While `wd_off` is 1, the timeout count is held at zero and no watchdog reset occurs. `wd_fault_n` is forced to 1 on the next edge.
- R8: When `lowline_in` is sampled 1, then on that same edge `rst_out_n` goes to 0, `lowline_n` goes to 0 and `wd_fault_n` is forced to 1.
- R9: After `lowline_in` returns to 0, `rst_out_n` stays 0 until RST_DLY edges after the last edge that sampled `lowline_in` high.
- R10: The timeout count is cleared while reset is asserted. A fresh full timeout starts when reset is released.
- R11: With `tsel`=1 the timeout is TO_SLOW cycles instead of TO_FAST, and no reset occurs at TO_FAST.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wd_strobe | input | 1 | Watchdog service strobe, asynchronous |
| wd_off | input | 1 | 1 = watchdog disabled (strobe floating or mid-level) |
| lowline_in | input | 1 | 1 = supply below threshold, synchronous |
| tsel | input | 1 | Timeout select: 0 = TO_FAST, 1 = TO_SLOW |
| rst_out_n | output | 1 | System reset, active low |
| rst_out | output | 1 | System reset, active high |
| wd_fault_n | output | 1 | Watchdog fault flag, active low |
| lowline_n | output | 1 | Registered low-line flag, active low |

## Verification
Each output has its own latency, and the checks follow it:
- Low-line effects on reset, the low-line flag and the fault flag are due one edge after `lowline_in` is applied.
- A strobe change reaches the fault flag on the third edge.
- A missed service shows up TO_FAST or TO_SLOW edges after the last clearing edge.
- A reset release comes RST_DLY edges after the last load of the delay counter.

Stimulus is driven on falling edges, and each check counts whole cycles to the exact falling edge just after the edge where the result is due. The bench also checks one cycle earlier that the result has not yet arrived. An output that is one edge early or one edge late is therefore reported as a failure.

// File: rtl/sup_pkg.sv
package sup_pkg;
  // events the watchdog timer hands to the reset and flag logic
  typedef struct packed {
    logic kick;    // registered strobe transition
    logic expire;  // timeout reached this cycle
  } wd_evt_t;

  function automatic int cnt_bits(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog
  import sup_pkg::*;
#(
  parameter int TO_FAST = 24,
  parameter int TO_SLOW = 60
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    strobe_s,
  input  logic    hold,
  input  logic    tsel,
  output wd_evt_t evt
);
  localparam int TMAX = (TO_SLOW > TO_FAST) ? TO_SLOW : TO_FAST;
  localparam int TW   = cnt_bits(TMAX);
  localparam logic [TW-1:0] LIM_F = TW'(TO_FAST - 1);
  localparam logic [TW-1:0] LIM_S = TW'(TO_SLOW - 1);

  logic          prev;
  logic [TW-1:0] wcnt;
  logic [TW-1:0] lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= strobe_s;
  end

  assign evt.kick   = strobe_s ^ prev;
  assign lim        = tsel ? LIM_S : LIM_F;
  assign evt.expire = !hold && !evt.kick && (wcnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            wcnt <= '0;
    else if (hold || evt.kick || evt.expire) wcnt <= '0;
    else                                   wcnt <= wcnt + 1'b1;
  end
endmodule

// File: rtl/sup_rstgen.sv
module sup_rstgen
  import sup_pkg::*;
#(
  parameter int RST_DLY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lowline,
  input  logic expire,
  output logic rst_act
);
  localparam int DW = cnt_bits(RST_DLY);
  localparam logic [DW-1:0] DLY = DW'(RST_DLY);

  logic [DW-1:0] dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 dcnt <= DLY;
    else if (lowline || expire) dcnt <= DLY;
    else if (dcnt != '0)        dcnt <= dcnt - 1'b1;
  end

  assign rst_act = (dcnt != '0);
endmodule

// File: rtl/sup_flags.sv
module sup_flags
  import sup_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    lowline,
  input  logic    wd_off,
  input  wd_evt_t evt,
  output logic    fault_n,
  output logic    lowline_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                fault_n <= 1'b1;
    else if (lowline || wd_off) fault_n <= 1'b1;
    else if (evt.expire)       fault_n <= 1'b0;
    else if (evt.kick)         fault_n <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowline_n <= 1'b1;
    else        lowline_n <= !lowline;
  end
endmodule

// File: rtl/sup_guard.sv
module sup_guard
  import sup_pkg::*;
#(
  parameter int RST_DLY = 12_500_000,
  parameter int TO_FAST = 25_000_000,
  parameter int TO_SLOW = 400_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_strobe,
  input  logic wd_off,
  input  logic lowline_in,
  input  logic tsel,
  output logic rst_out_n,
  output logic rst_out,
  output logic wd_fault_n,
  output logic lowline_n
);
  logic    strobe_s;
  logic    rst_act;
  wd_evt_t evt;

  sup_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(wd_strobe), .q(strobe_s)
  );

  sup_wdog #(.TO_FAST(TO_FAST), .TO_SLOW(TO_SLOW)) u_wdog (
    .clk(clk), .rst_n(rst_n), .strobe_s(strobe_s),
    .hold(wd_off || rst_act), .tsel(tsel), .evt(evt)
  );

  sup_rstgen #(.RST_DLY(RST_DLY)) u_rstgen (
    .clk(clk), .rst_n(rst_n), .lowline(lowline_in),
    .expire(evt.expire), .rst_act(rst_act)
  );

  sup_flags u_flags (
    .clk(clk), .rst_n(rst_n), .lowline(lowline_in), .wd_off(wd_off),
    .evt(evt), .fault_n(wd_fault_n), .lowline_n(lowline_n)
  );

  assign rst_out   = rst_act;
  assign rst_out_n = !rst_act;
endmodule

// File: rtl/sup_guard_chk.sv
module sup_guard_chk #(
  parameter int RST_DLY = 16
) (
  input logic clk,
  input logic rst_n,
  input logic wd_off,
  input logic lowline_in,
  input logic rst_out_n,
  input logic rst_out,
  input logic wd_fault_n,
  input logic lowline_n
);
  int unsigned hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      hold_cnt <= 0;
    else if (lowline_in || !rst_out) hold_cnt <= 0;
    else                             hold_cnt <= hold_cnt + 1;
  end

  p_polarity_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out == !rst_out_n);

  p_lowline_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lowline_in |=> !rst_out_n);

  p_lowline_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lowline_in |=> !lowline_n);

  p_lowline_clears_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lowline_in |=> wd_fault_n);

  p_off_clears_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_off |=> wd_fault_n);

  p_fault_with_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_fault_n) |-> $fell(rst_out_n));

  p_pulse_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_cnt <= RST_DLY);
endmodule

bind sup_guard sup_guard_chk #(.RST_DLY(RST_DLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .wd_off(wd_off), .lowline_in(lowline_in),
  .rst_out_n(rst_out_n), .rst_out(rst_out), .wd_fault_n(wd_fault_n),
  .lowline_n(lowline_n)
);

// File: tb/sup_guard_test.sv
module sup_guard_test;
  localparam int D = 16;
  localparam int F = 24;
  localparam int S = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wd_strobe = 1'b0;
  logic wd_off = 1'b1;
  logic lowline_in = 1'b0;
  logic tsel = 1'b0;
  logic rst_out_n, rst_out, wd_fault_n, lowline_n;

  int checks = 0;
  int errors = 0;

  always #2ns clk = ~clk;

  sup_guard #(.RST_DLY(D), .TO_FAST(F), .TO_SLOW(S)) uut (
    .clk(clk), .rst_n(rst_n), .wd_strobe(wd_strobe), .wd_off(wd_off),
    .lowline_in(lowline_in), .tsel(tsel), .rst_out_n(rst_out_n),
    .rst_out(rst_out), .wd_fault_n(wd_fault_n), .lowline_n(lowline_n)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wd_off = 1'b1; lowline_in = 1'b0; tsel = 1'b0; wd_strobe = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (D) @(negedge clk);
  endtask

  task automatic t_por();
    @(negedge clk);
    rst_n = 1'b0; wd_off = 1'b1;
    @(negedge clk);
    chk("R1", "rst_out_n in reset", rst_out_n, 1'b0);
    chk("R2", "rst_out in reset", rst_out, 1'b1);
    chk("R1", "wd_fault_n in reset", wd_fault_n, 1'b1);
    chk("R1", "lowline_n in reset", lowline_n, 1'b1);
    rst_n = 1'b1;
    repeat (D - 1) @(negedge clk);
    chk("R1", "rst_out_n before delay end", rst_out_n, 1'b0);
    @(negedge clk);
    chk("R1", "rst_out_n after delay", rst_out_n, 1'b1);
    chk("R2", "rst_out after delay", rst_out, 1'b0);
  endtask

  task automatic t_fast();
    do_reset();
    tsel = 1'b0; wd_off = 1'b0;
    repeat (F - 1) @(negedge clk);
    chk("R4", "reset one cycle before timeout", rst_out_n, 1'b1);
    chk("R4", "fault one cycle before timeout", wd_fault_n, 1'b1);
    @(negedge clk);
    chk("R4", "reset at timeout", rst_out_n, 1'b0);
    chk("R4", "fault at timeout", wd_fault_n, 1'b0);
    chk("R2", "rst_out at timeout", rst_out, 1'b1);
    repeat (D - 1) @(negedge clk);
    chk("R5", "pulse still active", rst_out_n, 1'b0);
    @(negedge clk);
    chk("R5", "pulse ended", rst_out_n, 1'b1);
    chk("R6", "fault held without strobe", wd_fault_n, 1'b0);
    repeat (F - 1) @(negedge clk);
    chk("R10", "no reset before fresh timeout", rst_out_n, 1'b1);
    @(negedge clk);
    chk("R10", "fresh timeout after release", rst_out_n, 1'b0);
    wd_strobe = ~wd_strobe;
    repeat (2) @(negedge clk);
    chk("R3", "fault before strobe registered", wd_fault_n, 1'b0);
    @(negedge clk);
    chk("R6", "fault cleared by strobe during pulse", wd_fault_n, 1'b1);
    wd_off = 1'b1;
  endtask

  task automatic t_slow();
    do_reset();
    tsel = 1'b1; wd_off = 1'b0;
    repeat (F) @(negedge clk);
    chk("R11", "no reset at fast timeout", rst_out_n, 1'b1);
    repeat (S - F - 1) @(negedge clk);
    chk("R11", "no reset before slow timeout", rst_out_n, 1'b1);
    @(negedge clk);
    chk("R11", "reset at slow timeout", rst_out_n, 1'b0);
    chk("R11", "fault at slow timeout", wd_fault_n, 1'b0);
    wd_off = 1'b1;
    @(negedge clk);
    chk("R7", "disable forces fault high", wd_fault_n, 1'b1);
  endtask

  task automatic t_kick();
    logic seen_rst;
    do_reset();
    tsel = 1'b0; wd_off = 1'b0;
    seen_rst = 1'b0;
    for (int i = 0; i < 12; i++) begin
      for (int j = 0; j < 10; j++) begin
        @(negedge clk);
        if (!rst_out_n) seen_rst = 1'b1;
      end
      wd_strobe = ~wd_strobe;
    end
    chk("R3", "serviced watchdog never resets", seen_rst, 1'b0);
    repeat (F + 2) @(negedge clk);
    chk("R3", "no reset one cycle before timeout from last strobe", rst_out_n, 1'b1);
    @(negedge clk);
    chk("R3", "timeout counted from last strobe", rst_out_n, 1'b0);
    wd_off = 1'b1;
  endtask

  task automatic t_off();
    logic seen_rst;
    do_reset();
    tsel = 1'b0; wd_off = 1'b1;
    seen_rst = 1'b0;
    for (int i = 0; i < 3 * S; i++) begin
      @(negedge clk);
      if (!rst_out_n || !wd_fault_n) seen_rst = 1'b1;
    end
    chk("R7", "disabled watchdog stays quiet", seen_rst, 1'b0);
  endtask

  task automatic t_lowline();
    do_reset();
    tsel = 1'b0; wd_off = 1'b0;
    repeat (F) @(negedge clk);
    chk("R4", "fault before low-line", wd_fault_n, 1'b0);
    repeat (D) @(negedge clk);
    chk("R5", "pulse over before low-line", rst_out_n, 1'b1);
    lowline_in = 1'b1;
    @(negedge clk);
    chk("R8", "reset on low-line", rst_out_n, 1'b0);
    chk("R8", "low-line flag", lowline_n, 1'b0);
    chk("R8", "fault forced high", wd_fault_n, 1'b1);
    repeat (5) @(negedge clk);
    lowline_in = 1'b0;
    repeat (D - 1) @(negedge clk);
    chk("R9", "reset held after recovery", rst_out_n, 1'b0);
    chk("R8", "low-line flag released", lowline_n, 1'b1);
    @(negedge clk);
    chk("R9", "reset released after delay", rst_out_n, 1'b1);
    repeat (F - 1) @(negedge clk);
    chk("R10", "counter restarted after low-line", rst_out_n, 1'b1);
    @(negedge clk);
    chk("R10", "timeout after low-line recovery", rst_out_n, 1'b0);
    wd_off = 1'b1;
  endtask

  initial begin
    #(4ns * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_por();
    t_fast();
    t_slow();
    t_kick();
    t_off();
    t_lowline();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule